// File: doc/BRIEF.md
# External Bus Bank Controller

This block turns internal word requests into cycles on an external SRAM, ROM or peripheral bus that is split into up to `NB` banks. Each bank has its own address window, data width (32 or 16 bits), wait-state source (a programmed count or the device's ready pin), and transfer style (burst or single). An address that matches no enabled bank is answered at once with an error and never reaches the pins.

A request is a 32-bit read or write. A read may also ask for a whole cache line of `LINE` words. Per bank, the words of a line come back either starting at the requested word and wrapping, or in order from word zero. On a 16-bit bank each word takes two external beats, and the halves are joined before the word is returned. Responses come one per word, each tagged with its index in the line and a last flag.

The controller is a three-state machine. **IDLE** accepts a request. It moves to **ACCESS** (transition *accept*) when the address hits a bank. On a miss it stays in IDLE and issues the error response (*miss*). ACCESS drives one beat and ends the beat when the wait timer completes. After the final beat it returns to IDLE (*finish*). After a timeout on a device-paced bank it also returns to IDLE (*expire*). Otherwise it stays in ACCESS for the next beat of a burst bank (*burst_next*), or goes to **GAP** for one idle cycle on a single-mode bank (*single_next*). GAP always returns to ACCESS (*resume*).

Top module: `xbus_bank_ctrl`

## Requirements
- R1: Out of reset the block is ready (`req_ready`=1), drives no chip select, no strobes, a zero address, and no response.
- R2: A request goes to the enabled bank b for which `((addr ^ base_b) & mask_b) == 0`. If several banks match, the lowest index wins. Only that bank's `ext_cs` bit is high during its beats, and at most one bit is ever high.
- R3: A request matching no enabled bank produces, in the next cycle, `resp_valid`=1 with `resp_err`=1 and `resp_last`=1. It drives no chip select and leaves the block ready.
- R4: On a bank with programmed waits, a beat holds chip select, strobe and address for exactly `wait`+1 cycles.
- R5: On a device-paced bank, a beat ends in the first cycle of the beat in which `ext_rdy` is sampled high.
- R6: If `ext_rdy` stays low for `cfg_tmo`+1 cycles of a paced beat, the access ends and an error response (`resp_err`=1, `resp_last`=1) appears in the next cycle.
- R7: On a 32-bit bank a word is one beat at a word-aligned byte address. On a 16-bit bank a word is two beats: byte offset 0 then offset 2. Read data is taken from `ext_din[15:0]` only and returned as {second half, first half}.
- R8: In burst mode the beats of one request follow each other with chip select held. The first beat uses `wait` and every later beat uses `bwait`.
- R9: In single mode, beats of one request are separated by exactly one cycle with chip select and strobes low, and every beat uses `wait`.
- R10: A read with `req_fill`=1 returns `LINE` words, one response each, with `resp_widx` giving the word index (request address bits [3:2] for `LINE`=4) and `resp_last` on the final word. With the bank's wrap bit set the order is target, target+1, … modulo `LINE`. With the wrap bit clear it is 0, 1, … `LINE`-1.
- R11: A write drives `req_wdata` on `ext_dout` with `ext_we`=1 and `ext_oe`=0; on a 16-bit bank bits 15:0 go out on the first beat and bits 31:16 on the second, both on `ext_dout[15:0]` with the upper pins zero. `req_fill` is ignored on writes (one word only).
- R12: Chip select drops for at least one cycle between any two requests. A new request is accepted in the cycle that carries the previous request's final response.
- R13: A word's response appears in the cycle after the clock edge that ends that word's last beat, with `resp_rdata` zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_fill | input | 1 | Read a whole cache line |
| req_addr | input | AW | Byte address of the requested word |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Miss or ready timeout |
| resp_last | output | 1 | Final response of the request |
| resp_widx | output | LB | Word index inside the line |
| resp_rdata | output | 32 | Read word |
| cfg_en | input | NB | Bank enable |
| cfg_base | input | NB*AW | Per-bank window base |
| cfg_mask | input | NB*AW | Per-bank window compare mask |
| cfg_wide | input | NB | 1 = 32-bit bank, 0 = 16-bit bank |
| cfg_paced | input | NB | 1 = wait on ext_rdy |
| cfg_burst | input | NB | 1 = burst, 0 = single |
| cfg_twf | input | NB | 1 = line fill starts at target word |
| cfg_wait | input | NB*WW | First-beat wait count |
| cfg_bwait | input | NB*WW | Later-beat wait count in burst |
| cfg_tmo | input | TW | Paced timeout limit |
| ext_cs | output | NB | Chip selects, active high |
| ext_oe | output | 1 | Output enable (read strobe) |
| ext_we | output | 1 | Write enable |
| ext_addr | output | AW | External byte address |
| ext_dout | output | 32 | Write data to the bus |
| ext_din | input | 32 | Read data from the bus |
| ext_rdy | input | 1 | Device-paced ready |

## Verification
A request is taken at the edge where `req_valid` and `req_ready` are both high. The first ACCESS cycle, or the error response after a miss, follows that edge directly. Each beat then lasts `wait`+1 or `bwait`+1 cycles, or until the cycle in which ready is seen, with one GAP cycle between single-mode beats. A word's response arrives in the cycle after its last beat. The bench turns each request into a per-cycle list of expected pin and response values from these rules. It samples at the falling edge of every cycle, so that every cycle of a beat, gap and response is compared at the cycle where the rules place it. The device model in the bench times ready from the chip-select and address pins alone.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int DW = 32;
    localparam int HW = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } xbus_state_e;
endpackage

// File: rtl/xbus_bank_decode.sv
module xbus_bank_decode #(
    parameter int NB = 8,
    parameter int AW = 32,
    localparam int IW = $clog2(NB)
) (
    input  logic [AW-1:0]    addr,
    input  logic [NB-1:0]    en,
    input  logic [NB*AW-1:0] base,
    input  logic [NB*AW-1:0] mask,
    output logic             hit,
    output logic [IW-1:0]    idx
);
    logic [NB-1:0] match;

    for (genvar g = 0; g < NB; g++) begin : g_win
        assign match[g] = en[g] &&
            (((addr ^ base[g*AW +: AW]) & mask[g*AW +: AW]) == '0);
    end

    // lowest matching index takes priority
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
    parameter int WW = 4,
    parameter int TW = 8,
    localparam int CW = (WW > TW) ? WW : TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          paced,
    input  logic          rdy,
    input  logic [WW-1:0] limit,
    input  logic [TW-1:0] tmo,
    output logic          done,
    output logic          expired
);
    logic [CW-1:0] cnt;

    assign done    = active && (paced ? rdy : (cnt == CW'(limit)));
    assign expired = active && paced && !rdy && (cnt == CW'(tmo));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= '0;
        else if (!active || done || expired) cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xbus_beat_addr.sv
module xbus_beat_addr #(
    parameter int AW = 32,
    parameter int LB = 2
) (
    input  logic [AW-3:0] word_addr,
    input  logic [LB-1:0] kw,
    input  logic          half,
    input  logic          wrap,
    input  logic          wide,
    output logic [LB-1:0] widx,
    output logic [AW-1:0] addr
);
    assign widx = wrap ? (word_addr[LB-1:0] + kw) : kw;
    assign addr = {word_addr[AW-3:LB], widx, half & ~wide, 1'b0};
endmodule

// File: rtl/xbus_bank_ctrl.sv
module xbus_bank_ctrl
    import xbus_pkg::*;
#(
    parameter int NB   = 8,
    parameter int AW   = 32,
    parameter int LINE = 4,
    parameter int WW   = 4,
    parameter int TW   = 8,
    localparam int LB  = $clog2(LINE),
    localparam int IW  = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_we,
    input  logic             req_fill,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic             resp_last,
    output logic [LB-1:0]    resp_widx,
    output logic [DW-1:0]    resp_rdata,
    input  logic [NB-1:0]    cfg_en,
    input  logic [NB*AW-1:0] cfg_base,
    input  logic [NB*AW-1:0] cfg_mask,
    input  logic [NB-1:0]    cfg_wide,
    input  logic [NB-1:0]    cfg_paced,
    input  logic [NB-1:0]    cfg_burst,
    input  logic [NB-1:0]    cfg_twf,
    input  logic [NB*WW-1:0] cfg_wait,
    input  logic [NB*WW-1:0] cfg_bwait,
    input  logic [TW-1:0]    cfg_tmo,
    output logic [NB-1:0]    ext_cs,
    output logic             ext_oe,
    output logic             ext_we,
    output logic [AW-1:0]    ext_addr,
    output logic [DW-1:0]    ext_dout,
    input  logic [DW-1:0]    ext_din,
    input  logic             ext_rdy
);
    xbus_state_e st, st_nx;

    logic          dec_hit;
    logic [IW-1:0] dec_idx;
    logic [IW-1:0] bank_r;
    logic          we_r, fill_r, wide_r, paced_r, burst_r, wrap_r, first_r, half;
    logic [WW-1:0] wait_r, bwait_r;
    logic [AW-3:0] waddr_r;
    logic [DW-1:0] wdata_r;
    logic [HW-1:0] lo_r;
    logic [LB-1:0] kw, bw_widx;
    logic [AW-1:0] bw_addr;
    logic          tmr_done, tmr_exp, word_end, beat_final, accept;
    logic          unused_lo;

    assign unused_lo  = ^req_addr[1:0];
    assign accept     = (st == ST_IDLE) && req_valid;
    assign word_end   = wide_r || half;
    assign beat_final = word_end && (!fill_r || kw == LB'(LINE - 1));

    xbus_bank_decode #(.NB(NB), .AW(AW)) u_dec (
        .addr(req_addr), .en(cfg_en), .base(cfg_base), .mask(cfg_mask),
        .hit(dec_hit), .idx(dec_idx)
    );

    xbus_wait_timer #(.WW(WW), .TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .active(st == ST_ACCESS),
        .paced(paced_r), .rdy(ext_rdy),
        .limit((burst_r && !first_r) ? bwait_r : wait_r),
        .tmo(cfg_tmo), .done(tmr_done), .expired(tmr_exp)
    );

    xbus_beat_addr #(.AW(AW), .LB(LB)) u_baddr (
        .word_addr(waddr_r), .kw(kw), .half(half), .wrap(wrap_r),
        .wide(wide_r), .widx(bw_widx), .addr(bw_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions: accept, miss, finish, expire, burst_next, single_next, resume
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (req_valid && dec_hit) st_nx = ST_ACCESS;
            ST_ACCESS: begin
                if (tmr_exp)       st_nx = ST_IDLE;
                else if (tmr_done) st_nx = beat_final ? ST_IDLE :
                                           (burst_r ? ST_ACCESS : ST_GAP);
            end
            ST_GAP:    st_nx = ST_ACCESS;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // request context, beat position and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_r <= '0; we_r <= 1'b0; fill_r <= 1'b0; wide_r <= 1'b0;
            paced_r <= 1'b0; burst_r <= 1'b0; wrap_r <= 1'b0; first_r <= 1'b0;
            half <= 1'b0; kw <= '0; wait_r <= '0; bwait_r <= '0;
            waddr_r <= '0; wdata_r <= '0; lo_r <= '0;
            resp_valid <= 1'b0; resp_err <= 1'b0; resp_last <= 1'b0;
            resp_widx <= '0; resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept && !dec_hit) begin
                resp_valid <= 1'b1; resp_err <= 1'b1; resp_last <= 1'b1;
                resp_widx  <= '0;   resp_rdata <= '0;
            end else if (accept) begin
                bank_r  <= dec_idx;
                we_r    <= req_we;
                fill_r  <= req_fill & ~req_we;
                wrap_r  <= cfg_twf[dec_idx] | ~(req_fill & ~req_we);
                wide_r  <= cfg_wide[dec_idx];
                paced_r <= cfg_paced[dec_idx];
                burst_r <= cfg_burst[dec_idx];
                wait_r  <= cfg_wait[dec_idx*WW +: WW];
                bwait_r <= cfg_bwait[dec_idx*WW +: WW];
                waddr_r <= req_addr[AW-1:2];
                wdata_r <= req_wdata;
                kw <= '0; half <= 1'b0; first_r <= 1'b1;
            end else if (tmr_exp) begin
                resp_valid <= 1'b1; resp_err <= 1'b1; resp_last <= 1'b1;
                resp_rdata <= '0;
            end else if (tmr_done) begin
                first_r <= 1'b0;
                if (!we_r && !word_end) lo_r <= ext_din[HW-1:0];
                if (word_end) begin
                    resp_valid <= 1'b1;
                    resp_err   <= 1'b0;
                    resp_last  <= beat_final;
                    resp_widx  <= bw_widx;
                    resp_rdata <= we_r   ? '0 :
                                  wide_r ? ext_din : {ext_din[HW-1:0], lo_r};
                    kw   <= kw + 1'b1;
                    half <= 1'b0;
                end else begin
                    half <= 1'b1;
                end
            end
        end
    end

    // pin and handshake outputs
    always_comb begin
        req_ready = (st == ST_IDLE);
        ext_cs    = '0;
        ext_oe    = 1'b0;
        ext_we    = 1'b0;
        ext_addr  = '0;
        ext_dout  = '0;
        if (st == ST_ACCESS) begin
            ext_cs[bank_r] = 1'b1;
            ext_oe   = !we_r;
            ext_we   = we_r;
            ext_addr = bw_addr;
            if (we_r)
                ext_dout = wide_r ? wdata_r :
                           {{(DW-HW){1'b0}}, half ? wdata_r[DW-1:HW] : wdata_r[HW-1:0]};
        end
    end
endmodule

// File: rtl/xbus_bank_ctrl_chk.sv
module xbus_bank_ctrl_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          dec_hit,
    input logic [NB-1:0] ext_cs,
    input logic          ext_oe,
    input logic          ext_we,
    input logic          resp_valid,
    input logic          resp_err,
    input logic          resp_last
);
    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_cs));

    p_miss_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !dec_hit) |=>
            (resp_valid && resp_err && ext_cs == '0));

    p_strobe_under_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_oe || ext_we) |-> (ext_cs != '0 && !(ext_oe && ext_we)));

    p_bank_switch_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs != '0 && $past(ext_cs) != '0) |-> (ext_cs == $past(ext_cs)));

    p_last_resp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_last) |-> req_ready);
endmodule

bind xbus_bank_ctrl xbus_bank_ctrl_chk #(.NB(NB)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .dec_hit(dec_hit), .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_we(ext_we),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_last(resp_last)
);

// File: tb/xbus_bank_ctrl_tb.sv
module xbus_bank_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8, AW = 32, LINE = 4, WW = 4, TW = 8, LB = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, req_fill = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic req_ready, resp_valid, resp_err, resp_last;
    logic [LB-1:0] resp_widx;
    logic [31:0] resp_rdata;
    logic [NB-1:0] cfg_en, cfg_wide, cfg_paced, cfg_burst, cfg_twf;
    logic [NB*AW-1:0] cfg_base, cfg_mask;
    logic [NB*WW-1:0] cfg_wait, cfg_bwait;
    logic [TW-1:0] cfg_tmo;
    logic [NB-1:0] ext_cs;
    logic ext_oe, ext_we, ext_rdy;
    logic [31:0] ext_addr, ext_dout, ext_din;

    int checks = 0, failures = 0;
    int rdy_delay = 0;

    // bench copy of bank setup
    int b_base[NB], b_mask[NB], b_wait[NB], b_bwait[NB];
    bit b_en[NB], b_wide[NB], b_paced[NB], b_burst[NB], b_twf[NB];
    int tmo_v = 5;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_bank_ctrl #(.NB(NB), .AW(AW), .LINE(LINE), .WW(WW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_fill(req_fill), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_last(resp_last), .resp_widx(resp_widx), .resp_rdata(resp_rdata),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_wide(cfg_wide), .cfg_paced(cfg_paced), .cfg_burst(cfg_burst),
        .cfg_twf(cfg_twf), .cfg_wait(cfg_wait), .cfg_bwait(cfg_bwait),
        .cfg_tmo(cfg_tmo), .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_we(ext_we),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .ext_rdy(ext_rdy)
    );

    // external device: data is a function of the address, ready after rdy_delay cycles
    function automatic logic [31:0] dev(input logic [31:0] a);
        return (a * 32'h0001_0193) ^ 32'h3C5A_96E1;
    endfunction

    assign ext_din = dev(ext_addr);

    logic [NB-1:0] p_cs = '0;
    logic [31:0]   p_addr = '0;
    int d_cnt = 0, d_cur;
    always_comb d_cur = (ext_cs != '0 && ext_cs == p_cs && ext_addr == p_addr) ? d_cnt + 1 : 0;
    assign ext_rdy = (ext_cs != '0) && (d_cur >= rdy_delay);
    always @(posedge clk) begin
        p_cs   <= ext_cs;
        p_addr <= ext_addr;
        d_cnt  <= d_cur;
    end

    // expected per-cycle values
    logic [NB-1:0] e_cs[256];
    logic          e_oe[256], e_we[256], e_rv[256], e_err[256], e_last[256];
    logic [31:0]   e_addr[256], e_do[256], e_rd[256];
    logic [LB-1:0] e_widx[256];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input bit we, input bit fill, input logic [31:0] a,
                           input logic [31:0] wd, input int bank, input string tag);
        int t = 0;
        bit err = 0;
        for (int i = 0; i < 256; i++) begin
            e_cs[i] = '0; e_oe[i] = 0; e_we[i] = 0; e_addr[i] = '0; e_do[i] = '0;
            e_rv[i] = 0; e_err[i] = 0; e_last[i] = 0; e_rd[i] = '0; e_widx[i] = '0;
        end
        if (bank < 0) begin
            e_rv[0] = 1; e_err[0] = 1; e_last[0] = 1;
        end else begin
            int nw = (fill && !we) ? LINE : 1;
            int nh = b_wide[bank] ? 1 : 2;
            int tgt = int'(a[3:2]);
            bit first = 1;
            for (int w = 0; w < nw && !err; w++) begin
                int widx = (b_twf[bank] || nw == 1) ? (tgt + w) % LINE : w;
                logic [31:0] wa = {a[31:4], 2'(widx), 2'b00};
                for (int h = 0; h < nh && !err; h++) begin
                    int dur;
                    int lim = (b_burst[bank] && !first) ? b_bwait[bank] : b_wait[bank];
                    if (b_paced[bank]) begin
                        if (rdy_delay <= tmo_v) dur = rdy_delay + 1;
                        else begin dur = tmo_v + 1; err = 1; end
                    end else dur = lim + 1;
                    for (int i = 0; i < dur; i++) begin
                        e_cs[t] = NB'(1) << bank; e_oe[t] = !we; e_we[t] = we;
                        e_addr[t] = wa + 32'(2 * h);
                        e_do[t] = !we ? 32'h0 : b_wide[bank] ? wd :
                                  (h == 1 ? {16'h0, wd[31:16]} : {16'h0, wd[15:0]});
                        t++;
                    end
                    first = 0;
                    if (err) begin
                        e_rv[t] = 1; e_err[t] = 1; e_last[t] = 1;
                    end else begin
                        if (h == nh - 1) begin
                            logic [31:0] d0 = dev(wa), d1 = dev(wa + 32'd2);
                            e_rv[t] = 1; e_widx[t] = 2'(widx); e_last[t] = (w == nw - 1);
                            e_rd[t] = we ? 32'h0 : b_wide[bank] ? d0 : {d1[15:0], d0[15:0]};
                        end
                        if (!(w == nw - 1 && h == nh - 1) && !b_burst[bank]) t++;
                    end
                end
            end
        end
        // drive the request; it is taken at the next rising edge
        req_valid = 1; req_we = we; req_fill = fill; req_addr = a; req_wdata = wd;
        check(req_ready == 1'b1, tag, "req_ready at issue", 128'(req_ready), 128'(1));
        for (int c = 0; c <= t; c++) begin
            @(negedge clk);
            if (c == 0) begin req_valid = 0; req_fill = 0; req_we = 0; end
            begin
                bit ok = (ext_cs == e_cs[c]) && (ext_oe == e_oe[c]) && (ext_we == e_we[c])
                      && (ext_addr == e_addr[c]) && (ext_dout == e_do[c])
                      && (resp_valid == e_rv[c]);
                if (ok && e_rv[c]) begin
                    ok = (resp_err == e_err[c]) && (resp_last == e_last[c]);
                    if (!e_err[c]) ok = ok && (resp_rdata == e_rd[c]) && (resp_widx == e_widx[c]);
                end
                check(ok, tag, $sformatf("cycle %0d cs/oe/we/addr/dout/rv/err/last/widx/rdata", c),
                      {ext_cs, ext_oe, ext_we, ext_addr, ext_dout, resp_valid, resp_err,
                       resp_last, resp_widx, resp_rdata},
                      {e_cs[c], e_oe[c], e_we[c], e_addr[c], e_do[c], e_rv[c], e_err[c],
                       e_last[c], e_widx[c], e_rd[c]});
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            b_en[b] = 0; b_base[b] = 0; b_mask[b] = 32'hFFFF_0000; b_wait[b] = 0;
            b_bwait[b] = 0; b_wide[b] = 1; b_paced[b] = 0; b_burst[b] = 0; b_twf[b] = 0;
        end
        // bank0: 32-bit, programmed, burst, target-first
        b_en[0] = 1; b_base[0] = 32'h0000_0000; b_wait[0] = 2; b_bwait[0] = 1;
        b_burst[0] = 1; b_twf[0] = 1;
        // bank1: 16-bit, programmed, single, sequential
        b_en[1] = 1; b_base[1] = 32'h0001_0000; b_wait[1] = 1; b_bwait[1] = 3; b_wide[1] = 0;
        // bank2: 32-bit, paced, burst, sequential
        b_en[2] = 1; b_base[2] = 32'h0002_0000; b_paced[2] = 1; b_burst[2] = 1;
        // bank3 overlaps the upper half of bank1
        b_en[3] = 1; b_base[3] = 32'h0001_8000; b_mask[3] = 32'hFFFF_8000; b_wait[3] = 4;
        // bank4 disabled
        b_base[4] = 32'h0003_0000;
        for (int b = 0; b < NB; b++) begin
            cfg_en[b] = b_en[b]; cfg_wide[b] = b_wide[b]; cfg_paced[b] = b_paced[b];
            cfg_burst[b] = b_burst[b]; cfg_twf[b] = b_twf[b];
            cfg_base[b*AW +: AW] = b_base[b]; cfg_mask[b*AW +: AW] = b_mask[b];
            cfg_wait[b*WW +: WW] = WW'(b_wait[b]); cfg_bwait[b*WW +: WW] = WW'(b_bwait[b]);
        end
        cfg_tmo = TW'(tmo_v);

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready && ext_cs == '0 && !ext_oe && !ext_we && ext_addr == '0 && !resp_valid,
              "R1", "reset state", {req_ready, ext_cs, ext_oe, ext_we, resp_valid},
              {1'b1, 8'h00, 1'b0, 1'b0, 1'b0});

        run_req(0, 0, 32'h0000_0104, 0, 0, "R4");           // 32-bit, wait 2
        run_req(0, 0, 32'h0001_0208, 0, 1, "R9");           // 16-bit halves, gap
        run_req(0, 0, 32'h0001_8010, 0, 1, "R2");           // overlap -> bank1
        run_req(0, 1, 32'h0000_0048, 0, 0, "R8");           // burst fill, wrap 2,3,0,1
        run_req(0, 1, 32'h0001_0034, 0, 1, "R10");          // sequential fill, 16-bit
        run_req(0, 0, 32'h0001_00F0, 0, 1, "R7");           // 16-bit assembly
        rdy_delay = 3; run_req(0, 0, 32'h0002_0010, 0, 2, "R5");
        rdy_delay = 5; run_req(0, 0, 32'h0002_0020, 0, 2, "R5");
        rdy_delay = 9; run_req(0, 0, 32'h0002_0030, 0, 2, "R6");
        rdy_delay = 0; run_req(0, 1, 32'h0002_0048, 0, 2, "R10");
        run_req(1, 1, 32'h0000_0208, 32'hDEAD_BEEF, 0, "R11"); // fill ignored on write
        run_req(1, 0, 32'h0001_0040, 32'h1234_5678, 1, "R11");
        run_req(0, 0, 32'h0003_0000, 0, -1, "R3");          // disabled bank
        run_req(0, 0, 32'h0009_0000, 0, -1, "R3");          // no window
        run_req(0, 0, 32'h0000_0010, 0, 0, "R12");          // back to back, bank change
        run_req(0, 0, 32'h0001_0010, 0, 1, "R12");
        run_req(0, 1, 32'h0000_004C, 0, 0, "R13");

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule